// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands (1 sign bit, 8 exponent bits, 23 fraction bits, exponent bias 127). It returns one product rounded to nearest, with ties going to the even significand. Every operand class is decoded: normal, subnormal, zero, infinity and NaN. The product's sign is the exclusive-OR of the input signs. Its exponent is the sum of the input exponents. The two 24-bit significands are multiplied and the result is normalized. It is then rounded using the kept LSB, the first dropped bit and the OR of all lower dropped bits. It is normalized a second time if rounding carries the significand up to 2.0.

Operands enter through a valid/ready handshake. The result sits in one output register and leaves through a second valid/ready handshake together with an overflow flag. A new operation is accepted whenever the output register is empty or is being drained in the same cycle. This gives one result per cycle when the consumer never stalls.

Top module: `fp32_mul_rne`

## Requirements
- R1: For finite nonzero operands whose rounded product lies in the normal range, the output has sign = sign_a XOR sign_b. Its value is the exact product rounded to 24 significant bits, packed with biased exponent in bits 30:23 and fraction in bits 22:0. `out_ovf` is 0.
- R2: When the exact significand product is at least 2.0, it is shifted right one place and the exponent is incremented, e.g. 1.5 × 1.5 gives 0x40100000.
- R3: Rounding uses the kept LSB (G), the first dropped bit (R) and the OR of all further dropped bits (S). The result rounds down when R=0 and up when R=1 and S=1. On a tie (R=1, S=0) it rounds up only when G=1, so 0x3F800001 × 0x3FC00000 gives 0x3FC00002 and 0x3F800003 × 0x3FC00000 gives 0x3FC00004.
- R4: When rounding carries the significand to 2.0, it is shifted right again and the exponent is incremented, so 0x3FFFFFFE × 0x3F800001 gives 0x40000000.
- R5: An operand with exponent field 0 and nonzero fraction is taken as 0.f × 2^-126, so 0x00400000 × 0x40800000 gives 0x01000000.
- R6: When the rounded exponent exceeds +127 for finite operands, the output is infinity with the product sign (exponent field 0xFF, fraction 0) and `out_ovf` is 1. In every other case `out_ovf` is 0.
- R7: When the rounded result is below 2^-126 in magnitude, or a finite operand meets a zero, the output is a zero carrying the product sign. The output never has exponent field 0 with a nonzero fraction.
- R8: A NaN operand (exponent 0xFF, fraction nonzero), or infinity times zero in either order, gives exactly 0x7FC00000 with `out_ovf` = 0.
- R9: Infinity times a nonzero finite value or infinity gives infinity with the product sign and `out_ovf` = 0.
- R10: `in_ready` is high when the output register is empty or `out_ready` is high. An operation accepted at a rising edge (`in_valid` and `in_ready`) shows its result with `out_valid` high right after that edge. `out_valid` falls after an edge where the result drains and nothing new is accepted.
- R11: While `out_valid` is high and `out_ready` is low, `out_prod`, `out_ovf` and `out_valid` hold their values.
- R12: After synchronous reset, `out_valid` is 0, `out_prod` is 0, `out_ovf` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | 32 | First operand, single-precision |
| in_b | input | 32 | Second operand, single-precision |
| out_valid | output | 1 | Product register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_prod | output | 32 | Rounded single-precision product |
| out_ovf | output | 1 | Product exponent exceeded the format |

## Verification
On every cycle the assertions cover the output-side invariants. An overflow flag must come with an infinite magnitude. Any NaN on the output must be the canonical one. No subnormal pattern may appear. An accepted operation must be followed by a valid result. A stalled result must hold steady. Whether a given product is correctly rounded can only be shown by the bench comparing it with an independently computed reference. The same applies to ties going to even, the second normalization after a rounding carry, the reading of subnormal inputs and the sign of flushed zeros. The bench does this over directed corner cases and a seeded random mix weighted toward subnormals, special values and exponents near both ends of the range.

// File: rtl/fp32m_pkg.sv
package fp32m_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX   = BIAS;
    localparam int EMIN   = 1 - BIAS;
    localparam int XE_W   = EXP_W + 4;
    localparam int LO_W   = $clog2(PROD_W);

    localparam logic [WORD_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        K_ZERO   = 2'd0,
        K_FINITE = 2'd1,
        K_INF    = 2'd2,
        K_NAN    = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic                    sign;
        op_kind_e                kind;
        logic signed [XE_W-1:0]  exp;   // unbiased exponent of sig's weight 2^0 position
        logic [SIG_W-1:0]        sig;   // h.fff..f
    } op_fields_t;

    typedef struct packed {
        logic                    sign;
        logic signed [XE_W-1:0]  exp;   // unbiased exponent of the leading one
        logic [PROD_W-1:0]       norm;  // leading one sits in the top bit
    } prod_norm_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              ovf;
    } mul_result_t;

    function automatic logic [LO_W-1:0] lead_one_pos(input logic [PROD_W-1:0] v);
        lead_one_pos = '0;
        for (int i = 0; i < PROD_W; i++) begin
            if (v[i]) lead_one_pos = LO_W'(i);
        end
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic s,
                                                    input logic [EXP_W-1:0] e,
                                                    input logic [FRAC_W-1:0] f);
        pack_word = {s, e, f};
    endfunction

endpackage

// File: rtl/fp32m_unpack.sv
module fp32m_unpack
    import fp32m_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output op_fields_t        op
);
    logic [EXP_W-1:0]  efield;
    logic [FRAC_W-1:0] ffield;
    logic              e_zero;
    logic              e_ones;
    logic              f_zero;

    assign efield = word[WORD_W-2 -: EXP_W];
    assign ffield = word[FRAC_W-1:0];
    assign e_zero = (efield == '0);
    assign e_ones = (efield == '1);
    assign f_zero = (ffield == '0);

    always_comb begin
        op.sign = word[WORD_W-1];
        op.exp  = XE_W'(EMIN);
        op.sig  = {1'b0, ffield};
        if (e_ones) begin
            op.kind = f_zero ? K_INF : K_NAN;
        end else if (e_zero) begin
            op.kind = f_zero ? K_ZERO : K_FINITE;
        end else begin
            op.kind = K_FINITE;
            op.exp  = XE_W'(efield) - XE_W'(BIAS);
            op.sig  = {1'b1, ffield};
        end
    end
endmodule

// File: rtl/fp32m_sigmul.sv
module fp32m_sigmul
    import fp32m_pkg::*;
(
    input  op_fields_t op_a,
    input  op_fields_t op_b,
    output prod_norm_t pn
);
    logic [PROD_W-1:0] raw;
    logic [LO_W-1:0]   lead;

    assign raw  = PROD_W'(op_a.sig) * PROD_W'(op_b.sig);
    assign lead = lead_one_pos(raw);

    always_comb begin
        pn.sign = op_a.sign ^ op_b.sign;
        pn.norm = raw << (LO_W'(PROD_W - 1) - lead);
        pn.exp  = op_a.exp + op_b.exp + XE_W'(lead) - XE_W'(PROD_W - 2);
    end
endmodule

// File: rtl/fp32m_finish.sv
module fp32m_finish
    import fp32m_pkg::*;
(
    input  op_kind_e    kind_a,
    input  op_kind_e    kind_b,
    input  prod_norm_t  pn,
    output mul_result_t res
);
    localparam int DROP_W = PROD_W - SIG_W;

    logic [SIG_W-1:0]        kept;
    logic                    g_bit, r_bit, s_bit, bump;
    logic [SIG_W:0]          rsum;
    logic [FRAC_W-1:0]       frac_r;
    logic signed [XE_W-1:0]  exp_r;
    logic                    any_nan, any_inf, any_zero;

    assign kept  = pn.norm[PROD_W-1 -: SIG_W];
    assign g_bit = kept[0];
    assign r_bit = pn.norm[DROP_W-1];
    assign s_bit = |pn.norm[DROP_W-2:0];
    assign bump  = r_bit & (s_bit | g_bit);
    assign rsum  = {1'b0, kept} + (SIG_W+1)'(bump);

    always_comb begin
        if (rsum[SIG_W]) begin
            frac_r = rsum[FRAC_W:1];
            exp_r  = pn.exp + XE_W'(1);
        end else begin
            frac_r = rsum[FRAC_W-1:0];
            exp_r  = pn.exp;
        end
    end

    assign any_nan  = (kind_a == K_NAN) || (kind_b == K_NAN) ||
                      (kind_a == K_INF && kind_b == K_ZERO) ||
                      (kind_a == K_ZERO && kind_b == K_INF);
    assign any_inf  = (kind_a == K_INF) || (kind_b == K_INF);
    assign any_zero = (kind_a == K_ZERO) || (kind_b == K_ZERO);

    always_comb begin
        res.ovf = 1'b0;
        if (any_nan) begin
            res.word = CANON_NAN;
        end else if (any_inf) begin
            res.word = pack_word(pn.sign, '1, '0);
        end else if (any_zero || pn.norm == '0) begin
            res.word = pack_word(pn.sign, '0, '0);
        end else if ($signed(exp_r) > $signed(XE_W'(EMAX))) begin
            res.word = pack_word(pn.sign, '1, '0);
            res.ovf  = 1'b1;
        end else if ($signed(exp_r) < $signed(XE_W'(EMIN))) begin
            res.word = pack_word(pn.sign, '0, '0);
        end else begin
            res.word = pack_word(pn.sign, EXP_W'(exp_r + XE_W'(BIAS)), frac_r);
        end
    end
endmodule

// File: rtl/fp32_mul_rne.sv
module fp32_mul_rne
    import fp32m_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_prod,
    output logic        out_ovf
);
    localparam int N_OPS = 2;

    logic [WORD_W-1:0] op_word [N_OPS];
    op_fields_t        op_f    [N_OPS];
    prod_norm_t        pn;
    mul_result_t       res_c;
    mul_result_t       res_q;
    logic              take;

    assign op_word[0] = in_a;
    assign op_word[1] = in_b;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_unpack
        fp32m_unpack u_unpack (
            .word (op_word[gi]),
            .op   (op_f[gi])
        );
    end

    fp32m_sigmul u_sigmul (
        .op_a (op_f[0]),
        .op_b (op_f[1]),
        .pn   (pn)
    );

    fp32m_finish u_finish (
        .kind_a (op_f[0].kind),
        .kind_b (op_f[1].kind),
        .pn     (pn),
        .res    (res_c)
    );

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            if (in_ready) out_valid <= in_valid;
            if (take)     res_q     <= res_c;
        end
    end

    assign out_prod = res_q.word;
    assign out_ovf  = res_q.ovf;

    assert_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_prod) && $stable(out_ovf)));

    assert_ovf_inf_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ovf) |-> (out_prod[30:0] == 31'h7F800000));

    assert_nan_canon_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_prod[30:23] == 8'hFF && out_prod[22:0] != 23'd0)
        |-> (out_prod == CANON_NAN && !out_ovf));

    assert_no_subnormal_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_prod[30:23] == 8'h00 && out_prod[22:0] != 23'd0));
endmodule

// File: tb/fp32_mul_rne_tb.sv
module fp32_mul_rne_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_prod;
    logic        out_ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp32_mul_rne u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_prod(out_prod), .out_ovf(out_ovf)
    );

    // Reference: exact product reduced bit by bit, then rounded to 24 bits.
    function automatic logic [32:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic s;
        logic [7:0] ea, eb;
        logic [22:0] fa, fb;
        logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
        longint unsigned ma, mb, m;
        int xa, xb, e;
        logic rb, sb;
        s  = a[31] ^ b[31];
        ea = a[30:23]; eb = b[30:23];
        fa = a[22:0];  fb = b[22:0];
        a_nan = (ea == 8'hFF) && (fa != 0);  b_nan = (eb == 8'hFF) && (fb != 0);
        a_inf = (ea == 8'hFF) && (fa == 0);  b_inf = (eb == 8'hFF) && (fb == 0);
        a_zero = (ea == 0) && (fa == 0);     b_zero = (eb == 0) && (fb == 0);
        if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero))
            return {1'b0, 32'h7FC00000};
        if (a_inf || b_inf) return {1'b0, s, 8'hFF, 23'd0};
        if (a_zero || b_zero) return {1'b0, s, 31'd0};
        ma = (ea == 0) ? 64'(fa) : (64'(fa) | (64'd1 << 23));
        mb = (eb == 0) ? 64'(fb) : (64'(fb) | (64'd1 << 23));
        xa = (ea == 0) ? -126 : int'(ea) - 127;
        xb = (eb == 0) ? -126 : int'(eb) - 127;
        m  = ma * mb;
        e  = xa + xb - 46;
        rb = 1'b0; sb = 1'b0;
        while (m >= (64'd1 << 24)) begin
            sb = sb | rb;
            rb = m[0];
            m  = m >> 1;
            e++;
        end
        while (m < (64'd1 << 23)) begin
            m = m << 1;
            e--;
        end
        if (rb && (sb || m[0])) m = m + 1;
        if (m == (64'd1 << 24)) begin
            m = m >> 1;
            e++;
        end
        e = e + 23;
        if (e > 127)  return {1'b1, s, 8'hFF, 23'd0};
        if (e < -126) return {1'b0, s, 31'd0};
        return {1'b0, s, 8'(e + 127), m[22:0]};
    endfunction

    function automatic string req_of(input logic [32:0] r);
        if (r[31:0] == 32'h7FC00000) return "R8";
        if (r[32])                   return "R6";
        if (r[30:23] == 8'hFF)       return "R9";
        if (r[30:0] == 31'd0)        return "R7";
        return "R1";
    endfunction

    function automatic logic [31:0] rand_operand();
        logic [31:0] w;
        int cat;
        w   = $urandom();
        cat = $urandom_range(0, 9);
        case (cat)
            0: ;
            1: w[30:23] = 8'h00;
            2: begin
                w[30:23] = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'hFF;
                if ($urandom_range(0, 1) == 0) w[22:0] = '0;
            end
            3, 4: w[30:23] = 8'($urandom_range(1, 254));
            5: w[30:23] = 8'($urandom_range(1, 20));
            6: w[30:23] = 8'($urandom_range(230, 254));
            default: w[30:23] = 8'($urandom_range(100, 154));
        endcase
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string req);
        logic [32:0] r;
        r = ref_mul(a, b);
        @(negedge clk);
        in_a = a; in_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " prod"}, out_prod, r[31:0]);
        check({req, " ovf"}, {31'd0, out_ovf}, {31'd0, r[32]});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] seed_val, hold_val, ca, cb;
        logic [32:0] r;
        seed_val = $urandom(32'h0000_5EED);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check("R12 out_valid", {31'd0, out_valid}, 32'd0);
        check("R12 out_prod", out_prod, 32'd0);
        check("R12 out_ovf", {31'd0, out_ovf}, 32'd0);
        check("R12 in_ready", {31'd0, in_ready}, 32'd1);
        rst = 1'b0;

        run_op(32'h3F800000, 32'h3F800000, "R1 one");
        run_op(32'hC0000000, 32'h40400000, "R1 sign");
        check("R1 neg six", out_prod, 32'hC0C00000);
        run_op(32'h3FC00000, 32'h3FC00000, "R2");
        check("R2 value", out_prod, 32'h40100000);
        run_op(32'h3F800001, 32'h3FC00000, "R3 tie odd");
        check("R3 tie up", out_prod, 32'h3FC00002);
        run_op(32'h3F800003, 32'h3FC00000, "R3 tie even");
        check("R3 tie down", out_prod, 32'h3FC00004);
        run_op(32'h3FFFFFFE, 32'h3F800001, "R4");
        check("R4 carry", out_prod, 32'h40000000);
        run_op(32'h00400000, 32'h40800000, "R5");
        check("R5 subnormal in", out_prod, 32'h01000000);
        run_op(32'h7F000000, 32'hC0000000, "R6");
        check("R6 neg inf", out_prod, 32'hFF800000);
        check("R6 flag", {31'd0, out_ovf}, 32'd1);
        run_op(32'h80800000, 32'h3F000000, "R7");
        check("R7 neg zero", out_prod, 32'h80000000);
        run_op(32'h00000001, 32'h00000001, "R7 tiny");
        run_op(32'h80000000, 32'h41200000, "R7 zero op");
        run_op(32'h7F800000, 32'h00000000, "R8 inf zero");
        check("R8 canon", out_prod, 32'h7FC00000);
        run_op(32'h3F800000, 32'hFF812345, "R8 nan in");
        run_op(32'hFF800000, 32'h40000000, "R9");
        check("R9 inf", out_prod, 32'hFF800000);
        check("R9 no ovf", {31'd0, out_ovf}, 32'd0);

        // R10 / R11: backpressure
        @(negedge clk);
        out_ready = 1'b0;
        in_a = 32'h40400000; in_b = 32'h40A00000; in_valid = 1'b1;
        @(negedge clk);
        hold_val = out_prod;
        check("R10 stall valid", {31'd0, out_valid}, 32'd1);
        check("R10 stall valid", hold_val, 32'h41700000);
        ca = 32'h3E800000; cb = 32'hC1000000;
        in_a = ca; in_b = cb;
        check("R10 not ready", {31'd0, in_ready}, 32'd0);
        repeat (2) @(negedge clk);
        check("R11 held prod", out_prod, hold_val);
        check("R11 held valid", {31'd0, out_valid}, 32'd1);
        out_ready = 1'b1;
        #1;
        check("R10 ready on drain", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        r = ref_mul(ca, cb);
        check("R10 next result", out_prod, r[31:0]);
        check("R10 next valid", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        check("R10 drained", {31'd0, out_valid}, 32'd0);

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [31:0] a, b;
            a = rand_operand();
            b = rand_operand();
            run_op(a, b, req_of(ref_mul(a, b)));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule